// File: doc/BRIEF.md
# Memory Protection Region Checker

This block checks every bus access against a table of eight programmable protection regions. For each access it returns three things one clock later: whether the access may complete, which region decided the outcome, and the memory attributes the system must apply. The attributes are a memory type, a shareable flag and a cache policy.

Regions are loaded through a write-only configuration port, one region per write. Each region holds a base, a size, an enable, a permission code, an execute-never bit and its attributes. Regions may overlap. The highest-numbered enabled region that matches the address wins. An address that no enabled region matches falls into a background region. The background region carries fixed default attributes and admits privileged accesses only.

Instruction fetches and data accesses are checked against the same table. A global enable turns checking on. While it is clear, every access passes with the default attributes.

Top module: `mpu_region_chk`

## Requirements
- R1: A region of size code `s` spans 2^(s+1) bytes, and codes 0 to 4 all mean 32 bytes. Address bits below the span are ignored in both the base and the access address. A region matches when the remaining upper bits are equal, so code 31 covers the whole 32-bit space.
- R2: When several enabled regions match an address, the one with the highest index (0 to 7) supplies the permission, execute-never bit and attributes. `rsp_region` reports that index and `rsp_bg` is 0.
- R3: With checking on and no enabled region matching, `rsp_bg` is 1 and `rsp_region` is 0. The access is allowed only if it is privileged. The attributes come from `req_addr[31:29]`:
  - 0: normal write-through, not shared
  - 1: normal write-back, not shared
  - 2: device, not shared
  - 3: normal write-back, not shared
  - 4: normal write-through, not shared
  - 5: device, shared
  - 6: device, not shared
  - 7: strongly-ordered
- R4: The permission code `ap` sets what each mode may do.
  - Privileged reads are allowed for codes 1, 2, 3, 5, 6 and 7.
  - Unprivileged reads are allowed for codes 2, 3, 6 and 7.
  - Privileged writes are allowed for codes 1, 2 and 3.
  - Unprivileged writes are allowed only for code 3.
  - Codes 0 and 4 deny everything.
  - A denied access gives `rsp_allow`=0 and `rsp_fault`=1.
- R5: A fetch (`req_fetch`=1) is judged as a read, and `req_write` is ignored for it. A fetch from a region whose execute-never bit is set faults, while data reads from that region follow R4.
- R6: While the global enable is 0, every access gives `rsp_allow`=1, `rsp_fault`=0, `rsp_bg`=1 and `rsp_region`=0, with the R3 default attributes.
- R7: The attribute encodings are:
  - `rsp_type`: 0 strongly-ordered, 1 device, 2 normal. A programmed type of 3 is reported as 2.
  - `rsp_cache`: 0 non-cacheable, 1 write-through, 2 write-back. A programmed cache code of 3 is reported as 2.
  - `rsp_cache` is 0 for any type other than normal.
- R8: A strongly-ordered result always reports `rsp_shr`=1, whatever shareable bit was programmed.
- R9: A request sampled at a rising edge produces its response at that same edge, with `rsp_valid`=1. A cycle without a request gives `rsp_valid`=0, and the other response outputs keep their last values.
- R10: A configuration write and a request sampled at the same edge: the request is judged against the table as it was before the write.
- R11: Reset disables all regions and clears the global enable. All response outputs go to 0.
- R12: A region with its enable bit clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write one region entry |
| cfg_idx | input | 3 | Region index written |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code (R1) |
| cfg_en | input | 1 | Region enable |
| cfg_ap | input | 3 | Permission code (R4) |
| cfg_xn | input | 1 | Execute-never |
| cfg_type | input | 2 | Memory type code (R7) |
| cfg_shr | input | 1 | Shareable bit |
| cfg_cache | input | 2 | Cache policy code (R7) |
| glb_we | input | 1 | Write the global enable |
| glb_en | input | 1 | Global enable value |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Instruction fetch |
| req_priv | input | 1 | Privileged access |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access prohibited |
| rsp_region | output | 3 | Deciding region index |
| rsp_bg | output | 1 | Background region or checking off |
| rsp_type | output | 2 | Exported memory type |
| rsp_shr | output | 1 | Exported shareable flag |
| rsp_cache | output | 2 | Exported cache policy |

## Verification
Every result of this block comes from a single register stage. A request, or a table write, driven before a rising edge shows its effect on the response outputs right after that edge. The bench drives on falling edges and samples on the following falling edge, half a cycle after the registering edge. For R10 the write and the request share one falling edge, so the expected value is taken from the table before the write. For R9 one extra idle falling edge is sampled to see `rsp_valid` drop while the other fields hold.

// File: rtl/mpu_region_chk.sv
module mpu_region_chk #(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [31:0]   cfg_base,
  input  logic [4:0]    cfg_size,
  input  logic          cfg_en,
  input  logic [2:0]    cfg_ap,
  input  logic          cfg_xn,
  input  logic [1:0]    cfg_type,
  input  logic          cfg_shr,
  input  logic [1:0]    cfg_cache,
  input  logic          glb_we,
  input  logic          glb_en,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  input  logic          req_write,
  input  logic          req_fetch,
  input  logic          req_priv,
  output logic          rsp_valid,
  output logic          rsp_allow,
  output logic          rsp_fault,
  output logic [IW-1:0] rsp_region,
  output logic          rsp_bg,
  output logic [1:0]    rsp_type,
  output logic          rsp_shr,
  output logic [1:0]    rsp_cache
);

  logic [NREG-1:0] r_en, r_xn, r_shr, hit;
  logic [31:0]     r_base  [NREG];
  logic [4:0]      r_size  [NREG];
  logic [2:0]      r_ap    [NREG];
  logic [1:0]      r_type  [NREG];
  logic [1:0]      r_cache [NREG];
  logic            glb_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_on <= 1'b0;
      r_en   <= '0;
      r_xn   <= '0;
      r_shr  <= '0;
      for (int i = 0; i < NREG; i++) begin
        r_base[i]  <= '0;
        r_size[i]  <= '0;
        r_ap[i]    <= '0;
        r_type[i]  <= '0;
        r_cache[i] <= '0;
      end
    end else begin
      if (glb_we) glb_on <= glb_en;
      if (cfg_we) begin
        r_en[cfg_idx]    <= cfg_en;
        r_xn[cfg_idx]    <= cfg_xn;
        r_shr[cfg_idx]   <= cfg_shr;
        r_base[cfg_idx]  <= cfg_base;
        r_size[cfg_idx]  <= cfg_size;
        r_ap[cfg_idx]    <= cfg_ap;
        r_type[cfg_idx]  <= cfg_type;
        r_cache[cfg_idx] <= cfg_cache;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_match
    logic [5:0]  span;
    logic [32:0] lowm;
    assign span = (r_size[g] < 5'd4) ? 6'd5 : {1'b0, r_size[g]} + 6'd1;
    assign lowm = (33'd1 << span) - 33'd1;
    assign hit[g] = r_en[g] && (((req_addr ^ r_base[g]) & ~lowm[31:0]) == 32'd0);
  end

  logic [IW-1:0] win;
  logic          any;
  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) begin
        win = IW'(i);
        any = 1'b1;
      end
  end

  logic [1:0] d_type, d_cache;
  logic       d_shr;
  always_comb begin
    d_shr = 1'b0;
    unique case (req_addr[31:29])
      3'd0:    begin d_type = 2'd2; d_cache = 2'd1; end
      3'd1:    begin d_type = 2'd2; d_cache = 2'd2; end
      3'd3:    begin d_type = 2'd2; d_cache = 2'd2; end
      3'd4:    begin d_type = 2'd2; d_cache = 2'd1; end
      3'd5:    begin d_type = 2'd1; d_cache = 2'd0; d_shr = 1'b1; end
      3'd7:    begin d_type = 2'd0; d_cache = 2'd0; d_shr = 1'b1; end
      default: begin d_type = 2'd1; d_cache = 2'd0; end
    endcase
  end

  logic [2:0] ap;
  logic       rd_ok, wr_ok, reg_ok;
  assign ap     = r_ap[win];
  assign rd_ok  = req_priv ? (ap inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 3'd7})
                           : (ap inside {3'd2, 3'd3, 3'd6, 3'd7});
  assign wr_ok  = req_priv ? (ap inside {3'd1, 3'd2, 3'd3}) : (ap == 3'd3);
  assign reg_ok = req_fetch ? (rd_ok && !r_xn[win]) : (req_write ? wr_ok : rd_ok);

  logic [1:0] g_type, g_cache;
  logic       g_shr;
  assign g_type  = (r_type[win] == 2'd3) ? 2'd2 : r_type[win];
  assign g_shr   = (g_type == 2'd0) ? 1'b1 : r_shr[win];
  assign g_cache = (g_type != 2'd2) ? 2'd0 : ((r_cache[win] == 2'd3) ? 2'd2 : r_cache[win]);

  logic use_reg, ok;
  assign use_reg = glb_on && any;
  assign ok      = !glb_on ? 1'b1 : (any ? reg_ok : req_priv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_region <= '0;
      rsp_bg     <= 1'b0;
      rsp_type   <= '0;
      rsp_shr    <= 1'b0;
      rsp_cache  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_allow  <= ok;
        rsp_fault  <= !ok;
        rsp_region <= use_reg ? win : '0;
        rsp_bg     <= !use_reg;
        rsp_type   <= use_reg ? g_type  : d_type;
        rsp_shr    <= use_reg ? g_shr   : d_shr;
        rsp_cache  <= use_reg ? g_cache : d_cache;
      end
    end
  end

endmodule

module mpu_region_chk_props #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_priv,
  input logic          rsp_valid,
  input logic          rsp_allow,
  input logic [IW-1:0] rsp_region,
  input logic          rsp_bg,
  input logic [1:0]    rsp_type,
  input logic          rsp_shr,
  input logic [1:0]    rsp_cache
);

  // R9
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  idle_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R8
  so_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_type == 2'd0) |-> rsp_shr);

  // R7
  cache_normal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_type != 2'd2) |-> (rsp_cache == 2'd0));

  // R7
  type_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_type != 2'd3));

  // R3
  bg_region_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bg) |-> (rsp_region == '0));

  // R3
  bg_priv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv) |=> (rsp_bg -> rsp_allow));

endmodule

bind mpu_region_chk mpu_region_chk_props #(.IW(IW)) u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
  .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_region(rsp_region),
  .rsp_bg(rsp_bg), .rsp_type(rsp_type), .rsp_shr(rsp_shr), .rsp_cache(rsp_cache)
);

// File: tb/mpu_region_chk_tb_top.sv
module mpu_region_chk_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        cfg_we = 0, cfg_en = 0, cfg_xn = 0, cfg_shr = 0;
  logic [2:0]  cfg_idx = 0, cfg_ap = 0;
  logic [31:0] cfg_base = 0;
  logic [4:0]  cfg_size = 0;
  logic [1:0]  cfg_type = 0, cfg_cache = 0;
  logic        glb_we = 0, glb_en = 0;
  logic        req_valid = 0, req_write = 0, req_fetch = 0, req_priv = 0;
  logic [31:0] req_addr = 0;
  logic        rsp_valid, rsp_allow, rsp_fault, rsp_bg, rsp_shr;
  logic [2:0]  rsp_region;
  logic [1:0]  rsp_type, rsp_cache;

  mpu_region_chk dut_i (.*);

  int checks = 0, errors = 0;
  bit m_en[8], m_xn[8], m_shr[8], m_glb = 0;
  logic [31:0] m_base[8];
  logic [4:0]  m_size[8];
  logic [2:0]  m_ap[8];
  logic [1:0]  m_type[8], m_cache[8];

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: %s", tag, msg); end
  endtask

  task automatic default_attr(input logic [31:0] a, output logic [1:0] t, output logic s, output logic [1:0] c);
    case (a[31:29])
      0: begin t = 2; s = 0; c = 1; end
      1: begin t = 2; s = 0; c = 2; end
      2: begin t = 1; s = 0; c = 0; end
      3: begin t = 2; s = 0; c = 2; end
      4: begin t = 2; s = 0; c = 1; end
      5: begin t = 1; s = 1; c = 0; end
      6: begin t = 1; s = 0; c = 0; end
      default: begin t = 0; s = 1; c = 0; end
    endcase
  endtask

  task automatic model(input logic [31:0] a, input bit w, f, p,
                       output logic ea, eb, output logic [2:0] er,
                       output logic [1:0] et, output logic es, output logic [1:0] ec);
    int win = -1;
    bit rd, wr;
    default_attr(a, et, es, ec);
    er = 0; eb = 1;
    if (!m_glb) begin ea = 1; return; end
    for (int i = 0; i < 8; i++) begin
      int n = (m_size[i] < 4) ? 5 : m_size[i] + 1;
      if (m_en[i] && ((a >> n) == (m_base[i] >> n))) win = i;
    end
    if (win < 0) begin ea = p; return; end
    eb = 0; er = 3'(win);
    case (m_ap[win])
      1: begin rd = p;    wr = p;    end
      2: begin rd = 1;    wr = p;    end
      3: begin rd = 1;    wr = 1;    end
      5: begin rd = p;    wr = 0;    end
      6, 7: begin rd = 1; wr = 0;    end
      default: begin rd = 0; wr = 0; end
    endcase
    ea = f ? (rd && !m_xn[win]) : (w ? wr : rd);
    et = (m_type[win] == 3) ? 2 : m_type[win];
    es = (et == 0) ? 1 : m_shr[win];
    ec = (et != 2) ? 0 : ((m_cache[win] == 3) ? 2 : m_cache[win]);
  endtask

  task automatic cfg_write(input int idx, input logic [31:0] b, input logic [4:0] sz, input bit en,
                           input logic [2:0] ap, input bit xn, input logic [1:0] ty,
                           input bit sh, input logic [1:0] ca);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_base = b; cfg_size = sz; cfg_en = en;
    cfg_ap = ap; cfg_xn = xn; cfg_type = ty; cfg_shr = sh; cfg_cache = ca;
    @(negedge clk);
    cfg_we = 0;
    m_en[idx] = en; m_base[idx] = b; m_size[idx] = sz; m_ap[idx] = ap;
    m_xn[idx] = xn; m_type[idx] = ty; m_shr[idx] = sh; m_cache[idx] = ca;
  endtask

  task automatic set_glb(input bit v);
    @(negedge clk); glb_we = 1; glb_en = v;
    @(negedge clk); glb_we = 0; m_glb = v;
  endtask

  task automatic compare(input logic [31:0] a, input string tag,
                         input logic ea, eb, input logic [2:0] er,
                         input logic [1:0] et, input logic es, input logic [1:0] ec);
    check(rsp_valid === 1 && rsp_allow === ea && rsp_fault === !ea && rsp_bg === eb &&
          rsp_region === er && rsp_type === et && rsp_shr === es && rsp_cache === ec, tag,
          $sformatf("addr=%h got v%0b a%0b f%0b bg%0b r%0d t%0d s%0b c%0d exp a%0b bg%0b r%0d t%0d s%0b c%0d",
                    a, rsp_valid, rsp_allow, rsp_fault, rsp_bg, rsp_region, rsp_type, rsp_shr, rsp_cache,
                    ea, eb, er, et, es, ec));
  endtask

  task automatic access(input logic [31:0] a, input bit w, f, p, input string tag);
    logic ea, eb, es; logic [2:0] er; logic [1:0] et, ec;
    model(a, w, f, p, ea, eb, er, et, es, ec);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_fetch = f; req_priv = p;
    @(negedge clk);
    req_valid = 0;
    compare(a, tag, ea, eb, er, et, es, ec);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_en[i] = 0; m_xn[i] = 0; m_shr[i] = 0; m_base[i] = 0;
      m_size[i] = 0; m_ap[i] = 0; m_type[i] = 0; m_cache[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(rsp_valid === 0 && rsp_allow === 0 && rsp_fault === 0 && rsp_bg === 0 &&
          rsp_region === 0 && rsp_type === 0 && rsp_shr === 0 && rsp_cache === 0, "R11",
          $sformatf("got v%0b a%0b f%0b bg%0b r%0d exp all zero", rsp_valid, rsp_allow, rsp_fault, rsp_bg, rsp_region));
    rst_n = 1;

    // R11 / R6: after reset checking is off and all regions disabled
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++)
        access({3'(s), 29'h0123_4560}, k[0], 0, k[1], "R6");

    set_glb(1);
    // R3: background region by address segment, privilege and kind
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 3; k++)
          access({3'(s), 29'h00AB_CDE0}, k == 1, k == 2, p[0], "R3");

    // R4 / R5: every permission code against every mode and kind
    for (int ap = 0; ap < 8; ap++)
      for (int xn = 0; xn < 2; xn++) begin
        cfg_write(3, 32'h1000_0000, 5'd11, 1, 3'(ap), xn[0], 2, 0, 2);
        for (int p = 0; p < 2; p++)
          for (int k = 0; k < 3; k++)
            access(32'h1000_0A40, k == 1, k == 2, p[0], (k == 2) ? "R5" : "R4");
      end
    // R5: write flag ignored on fetch
    cfg_write(3, 32'h1000_0000, 5'd11, 1, 3'd6, 0, 2, 0, 2);
    access(32'h1000_0004, 1, 1, 1, "R5");
    cfg_write(3, 32'h0, 5'd0, 0, 0, 0, 0, 0, 0);

    // R2 / R1: nested regions, smaller ones higher numbered, unaligned bases
    for (int k = 0; k < 8; k++)
      cfg_write(k, 32'h4000_0000 | 32'(k * 3), 5'(20 - 2 * k), 1, 3'(k % 4 == 0 ? 3 : k % 4), 0,
                2'(k % 3), k[0], 2'(k % 4));
    for (int j = 0; j < 24; j++)
      for (int p = 0; p < 2; p++)
        access(32'h4000_0000 + (32'd1 << j) - 32'd1, 0, 0, p[0], "R2");
    // R1: size codes below 4 mean 32 bytes
    cfg_write(7, 32'h4000_0000, 5'd2, 1, 3'd3, 0, 2, 0, 1);
    access(32'h4000_001F, 0, 0, 0, "R1");
    access(32'h4000_0020, 0, 0, 0, "R1");
    // R1: code 31 covers everything
    cfg_write(1, 32'h0, 5'd31, 1, 3'd3, 0, 2, 0, 2);
    access(32'hF000_0000, 1, 0, 0, "R1");
    access(32'h0000_0000, 0, 1, 0, "R1");

    // R12: disabled region stops matching
    cfg_write(7, 32'h4000_0000, 5'd2, 0, 3'd0, 0, 2, 0, 1);
    access(32'h4000_0010, 0, 0, 0, "R12");
    for (int k = 0; k < 8; k++) cfg_write(k, 32'h0, 5'd0, 0, 0, 0, 0, 0, 0);
    access(32'h4000_0010, 0, 0, 0, "R12");

    // R7 / R8: attribute export
    cfg_write(0, 32'h8000_0000, 5'd27, 1, 3'd3, 0, 2'd0, 0, 2'd2);
    access(32'h8123_4568, 0, 0, 1, "R8");
    cfg_write(0, 32'h8000_0000, 5'd27, 1, 3'd3, 0, 2'd1, 0, 2'd1);
    access(32'h8123_4568, 0, 0, 1, "R7");
    cfg_write(0, 32'h8000_0000, 5'd27, 1, 3'd3, 0, 2'd3, 1, 2'd3);
    access(32'h8123_4568, 0, 0, 1, "R7");
    cfg_write(0, 32'h8000_0000, 5'd27, 1, 3'd3, 0, 2'd2, 1, 2'd0);
    access(32'h8123_4568, 0, 0, 1, "R7");

    // R10: write and request at the same edge see the old table
    begin
      logic ea, eb, es; logic [2:0] er; logic [1:0] et, ec;
      model(32'h8000_0100, 1, 0, 0, ea, eb, er, et, es, ec);
      @(negedge clk);
      cfg_we = 1; cfg_idx = 5; cfg_base = 32'h8000_0000; cfg_size = 5'd8; cfg_en = 1;
      cfg_ap = 3'd0; cfg_xn = 0; cfg_type = 2; cfg_shr = 0; cfg_cache = 0;
      req_valid = 1; req_addr = 32'h8000_0100; req_write = 1; req_fetch = 0; req_priv = 0;
      @(negedge clk);
      cfg_we = 0; req_valid = 0;
      compare(32'h8000_0100, "R10", ea, eb, er, et, es, ec);
      m_en[5] = 1; m_base[5] = 32'h8000_0000; m_size[5] = 5'd8; m_ap[5] = 0;
      m_xn[5] = 0; m_type[5] = 2; m_shr[5] = 0; m_cache[5] = 0;
      access(32'h8000_0100, 1, 0, 0, "R10");
    end

    // R9: idle cycle drops valid, fields hold
    @(negedge clk);
    check(rsp_valid === 0 && rsp_region === 3'd5 && rsp_fault === 1, "R9",
          $sformatf("got v%0b r%0d f%0b exp v0 r5 f1", rsp_valid, rsp_region, rsp_fault));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule